// File: doc/BRIEF.md
# Vectored Two-Level Interrupt Controller

This block sits between a set of on-chip peripherals and a small CPU core. It gathers fifteen request slots, one of them permanently reserved, and masks them with a global enable plus one enable bit per slot. It then sorts the survivors into two priority levels and picks a winner by slot number within the winning level. The core sees a request strobe and a 16-bit handler address. The strobe stays up until the core acknowledges it.

Four slots (the two external events and the two basic timer overflows) keep their pending state inside the controller. That state is cleared automatically when the core takes the vector. Every other slot arrives as a level formed from one or more peripheral flags. Those levels stay asserted until the peripheral's own software clears them. The controller also tracks which levels are currently in service, so that a running low-level handler can be interrupted by a high-level request while a running high-level handler cannot be interrupted at all. A return pulse from the core closes the most recently entered level.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request pending, irq_req is 0 and irq_vec reads 0x0000, the reset entry address, which no enable setting can hide.
- R2: Slot n (0..14) is reported as irq_vec = 0x0003 + 8*n. The slots in order are: external event A, timer 0, external event B, timer 1, serial port, timer 2, SPI, SMBus, port match, ADC window, ADC done, PCA, comparator, reserved, timer 3.
- R3: Among requests of the same level, the lowest slot number wins.
- R4: A slot's level is bit n of the 15-bit word {pri_x, pri_base[6:0]}; a 1 means high. A high request beats any low request regardless of slot number.
- R5: A slot takes part only when bit n of {en_x, en_base[6:0]} is 1 and the global bit en_base[7] is 1. With the global bit at 0, no new request is raised.
- R6: Slot 13 is never requested; en_x[6] and pri_x[6] have no effect.
- R7: Slots 0..3 hold a pending bit set by a one-cycle pulse on evt_set[n] and cleared on the cycle the core acknowledges that slot's vector; a set pulse in that same cycle wins. All other slots follow their input level and are not cleared by vectoring.
- R8: Grouped sources are ORed into one slot: serial port (2 flags), timer 2 (2), SPI (4), PCA (PCA_MODS compare flags plus 2 overflow flags), comparator (2 edge flags), timer 3 (2).
- R9: The port-match slot has no stored bit; its request is the live match input gated by its enable.
- R10: irq_req rises on the clock edge that sees a qualifying request. It then holds with an unchanged irq_vec until irq_ack is sampled high, and falls on the next edge. No new selection happens while irq_req is high.
- R11: An acknowledged vector enters its level into service. A low request is accepted only when no level is in service. A high request is accepted unless a high level is in service. An irq_reti pulse ends the high level if one is active, otherwise the low level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_base | input | 8 | Enables for slots 0..6; bit 7 is the global enable |
| en_x | input | 8 | Enables for slots 7..12 (bits 0..5) and 14 (bit 7) |
| pri_base | input | 8 | Level bits for slots 0..6; bit 7 unused |
| pri_x | input | 8 | Level bits for slots 7..12 (bits 0..5) and 14 (bit 7) |
| evt_set | input | 4 | Set pulses for the stored pending bits of slots 0..3 |
| ser_flags | input | 2 | Serial port receive/transmit flags |
| tmr2_flags | input | 2 | Timer 2 overflow flags |
| spi_flags | input | 4 | SPI flags |
| smb_flag | input | 1 | SMBus flag |
| port_match | input | 1 | Live port-match condition |
| adc_win_flag | input | 1 | ADC window compare flag |
| adc_done_flag | input | 1 | ADC conversion done flag |
| pca_flags | input | PCA_MODS+2 | PCA module and overflow flags |
| cmp_flags | input | 2 | Comparator edge flags |
| tmr3_flags | input | 2 | Timer 3 overflow flags |
| irq_ack | input | 1 | Core takes the presented vector |
| irq_reti | input | 1 | Core leaves the current handler |
| irq_req | output | 1 | Request strobe to the core |
| irq_vec | output | 16 | Handler address |

## Verification
The assertions take for granted that the core acknowledges only while irq_req is high. They also assume it never raises irq_ack and irq_reti in the same cycle, and issues irq_reti only while a handler is in service. The random stimulus keeps to these rules by deriving acknowledge and return from the bench's own model of the request and service state. The flags, set pulses and enable and level words are left free to change on any cycle, which exercises races between a pending bit being set and being cleared.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned SRC_N     = 15;
    localparam int unsigned IDX_W     = $clog2(SRC_N);
    localparam int unsigned VEC_W     = 16;
    localparam int unsigned AUTO_N    = 4;
    localparam int unsigned RSVD_IDX  = 13;
    localparam int unsigned VEC_SHIFT = 3;
    localparam logic [VEC_W-1:0] VEC_BASE  = 16'h0003;
    localparam logic [VEC_W-1:0] RESET_VEC = 16'h0000;

    typedef enum logic {LVL_LOW = 1'b0, LVL_HIGH = 1'b1} lvl_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        lvl_e             lvl;
    } grant_t;

    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        return VEC_BASE + (VEC_W'(idx) << VEC_SHIFT);
    endfunction

    // Joins the base and extended byte into one per-slot mask; the reserved slot is forced off.
    function automatic logic [SRC_N-1:0] slot_mask(input logic [7:0] base, input logic [7:0] ext);
        logic [SRC_N-1:0] m;
        m = {ext, base[6:0]};
        m[RSVD_IDX] = 1'b0;
        return m;
    endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
    import irq_pkg::*;
#(
    parameter int unsigned PCA_MODS = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [AUTO_N-1:0]     evt_set,
    input  logic [AUTO_N-1:0]     ack_clr,
    input  logic [1:0]            ser_flags,
    input  logic [1:0]            tmr2_flags,
    input  logic [3:0]            spi_flags,
    input  logic                  smb_flag,
    input  logic                  port_match,
    input  logic                  adc_win_flag,
    input  logic                  adc_done_flag,
    input  logic [PCA_MODS+1:0]   pca_flags,
    input  logic [1:0]            cmp_flags,
    input  logic [1:0]            tmr3_flags,
    output logic [SRC_N-1:0]      pend
);
    logic [AUTO_N-1:0] auto_q;

    for (genvar i = 0; i < AUTO_N; i++) begin : g_auto
        always_ff @(posedge clk) begin
            if (rst)             auto_q[i] <= 1'b0;
            else if (evt_set[i]) auto_q[i] <= 1'b1;
            else if (ack_clr[i]) auto_q[i] <= 1'b0;
        end

        // R7
        ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (ack_clr[i] && !evt_set[i]) |=> !auto_q[i]);

        // R7
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            evt_set[i] |=> auto_q[i]);
    end

    always_comb begin
        pend             = '0;
        pend[AUTO_N-1:0] = auto_q;
        pend[4]          = |ser_flags;
        pend[5]          = |tmr2_flags;
        pend[6]          = |spi_flags;
        pend[7]          = smb_flag;
        pend[8]          = port_match;
        pend[9]          = adc_win_flag;
        pend[10]         = adc_done_flag;
        pend[11]         = |pca_flags;
        pend[12]         = |cmp_flags;
        pend[RSVD_IDX]   = 1'b0;
        pend[14]         = |tmr3_flags;
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] pend,
    input  logic [SRC_N-1:0] en_mask,
    input  logic [SRC_N-1:0] hi_mask,
    input  logic             gie,
    input  logic             act_lo,
    input  logic             act_hi,
    output grant_t           grant
);
    logic [SRC_N-1:0] live, cand_hi, cand_lo, pick;
    logic             hi_ok, lo_ok;

    always_comb begin
        live    = pend & en_mask & {SRC_N{gie}};
        cand_hi = live & hi_mask;
        cand_lo = live & ~hi_mask;
        hi_ok   = (|cand_hi) && !act_hi;
        lo_ok   = (|cand_lo) && !act_hi && !act_lo;
        pick    = hi_ok ? cand_hi : cand_lo;
        grant       = '0;
        grant.valid = hi_ok || lo_ok;
        grant.lvl   = hi_ok ? LVL_HIGH : LVL_LOW;
        for (int i = int'(SRC_N) - 1; i >= 0; i--) begin
            if (pick[i]) grant.idx = IDX_W'(i);
        end
    end

    // R5
    grant_src_chk: assert property (@(posedge clk) disable iff (rst)
        grant.valid |-> (pend[grant.idx] && en_mask[grant.idx] && gie));

    // R6
    grant_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        grant.valid |-> (grant.idx != IDX_W'(RSVD_IDX)));
endmodule

// File: rtl/irq_svc_tracker.sv
module irq_svc_tracker
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  lvl_e push_lvl,
    input  logic pop,
    output logic act_lo,
    output logic act_hi
);
    logic nxt_lo, nxt_hi;

    always_comb begin
        nxt_lo = act_lo;
        nxt_hi = act_hi;
        if (pop) begin
            if (act_hi) nxt_hi = 1'b0;
            else        nxt_lo = 1'b0;
        end
        if (push) begin
            if (push_lvl == LVL_HIGH) nxt_hi = 1'b1;
            else                      nxt_lo = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_lo <= 1'b0;
            act_hi <= 1'b0;
        end else begin
            act_lo <= nxt_lo;
            act_hi <= nxt_hi;
        end
    end

    // R11
    low_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (push && push_lvl == LVL_LOW) |-> (!act_lo && !act_hi));

    // R11
    high_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (push && push_lvl == LVL_HIGH) |-> !act_hi);

    // R11
    pop_order_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && act_hi && !push) |=> (!act_hi && act_lo == $past(act_lo)));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned PCA_MODS = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [7:0]          en_base,
    input  logic [7:0]          en_x,
    input  logic [7:0]          pri_base,
    input  logic [7:0]          pri_x,
    input  logic [3:0]          evt_set,
    input  logic [1:0]          ser_flags,
    input  logic [1:0]          tmr2_flags,
    input  logic [3:0]          spi_flags,
    input  logic                smb_flag,
    input  logic                port_match,
    input  logic                adc_win_flag,
    input  logic                adc_done_flag,
    input  logic [PCA_MODS+1:0] pca_flags,
    input  logic [1:0]          cmp_flags,
    input  logic [1:0]          tmr3_flags,
    input  logic                irq_ack,
    input  logic                irq_reti,
    output logic                irq_req,
    output logic [15:0]         irq_vec
);
    logic [SRC_N-1:0]  pend, en_mask, hi_mask;
    logic [AUTO_N-1:0] ack_clr;
    grant_t            grant, held;
    logic              req_q, take, svc_lo, svc_hi;
    logic [VEC_W-1:0]  vec_q;
    logic              unused_bits;

    assign en_mask     = slot_mask(en_base, en_x);
    assign hi_mask     = slot_mask(pri_base, pri_x);
    assign take        = req_q && irq_ack;
    assign unused_bits = pri_base[7];

    for (genvar i = 0; i < AUTO_N; i++) begin : g_clr
        assign ack_clr[i] = take && (held.idx == IDX_W'(i));
    end

    irq_pend_bank #(.PCA_MODS(PCA_MODS)) pend_i (
        .clk(clk), .rst(rst), .evt_set(evt_set), .ack_clr(ack_clr),
        .ser_flags(ser_flags), .tmr2_flags(tmr2_flags), .spi_flags(spi_flags),
        .smb_flag(smb_flag), .port_match(port_match), .adc_win_flag(adc_win_flag),
        .adc_done_flag(adc_done_flag), .pca_flags(pca_flags), .cmp_flags(cmp_flags),
        .tmr3_flags(tmr3_flags), .pend(pend)
    );

    irq_arbiter arb_i (
        .clk(clk), .rst(rst), .pend(pend), .en_mask(en_mask), .hi_mask(hi_mask),
        .gie(en_base[7]), .act_lo(svc_lo), .act_hi(svc_hi), .grant(grant)
    );

    irq_svc_tracker svc_i (
        .clk(clk), .rst(rst), .push(take), .push_lvl(held.lvl), .pop(irq_reti),
        .act_lo(svc_lo), .act_hi(svc_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            vec_q <= RESET_VEC;
            held  <= '0;
        end else if (req_q) begin
            if (irq_ack) req_q <= 1'b0;
        end else if (grant.valid) begin
            req_q <= 1'b1;
            vec_q <= vec_of(grant.idx);
            held  <= grant;
        end
    end

    assign irq_req = req_q;
    assign irq_vec = vec_q;

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));

    // R10
    drop_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_ack) |=> !irq_req);

    // R5
    gie_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_req && !en_base[7]) |=> !irq_req);

    // R11
    no_hi_preempt_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_req && svc_hi) |=> !irq_req);

    // R2
    vec_form_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec[2:0] == 3'b011 && irq_vec != vec_of(IDX_W'(RSVD_IDX))));
endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;
    localparam int PCA_M = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic [7:0] en_base, en_x, pri_base, pri_x;
    logic [3:0] evt_set, spi_f;
    logic [1:0] ser_f, t2_f, cmp_f, t3_f;
    logic smb_f, pm, adcw_f, adcd_f, irq_ack, irq_reti;
    logic [PCA_M+1:0] pca_f;
    logic irq_req;
    logic [15:0] irq_vec;

    int checks = 0;
    int fails  = 0;

    logic m_req, m_lvl, m_lo, m_hi;
    logic [15:0] m_vec;
    int m_idx;
    logic [3:0] m_auto;

    irq_vector_ctrl #(.PCA_MODS(PCA_M)) dut_i (
        .clk(clk), .rst(rst), .en_base(en_base), .en_x(en_x), .pri_base(pri_base),
        .pri_x(pri_x), .evt_set(evt_set), .ser_flags(ser_f), .tmr2_flags(t2_f),
        .spi_flags(spi_f), .smb_flag(smb_f), .port_match(pm), .adc_win_flag(adcw_f),
        .adc_done_flag(adcd_f), .pca_flags(pca_f), .cmp_flags(cmp_f), .tmr3_flags(t3_f),
        .irq_ack(irq_ack), .irq_reti(irq_reti), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    function automatic logic [14:0] b_pend();
        logic [14:0] p;
        p[3:0] = m_auto;
        p[4]  = |ser_f;  p[5]  = |t2_f;  p[6]  = |spi_f;  p[7] = smb_f;
        p[8]  = pm;      p[9]  = adcw_f; p[10] = adcd_f;  p[11] = |pca_f;
        p[12] = |cmp_f;  p[13] = 1'b0;   p[14] = |t3_f;
        return p;
    endfunction

    function automatic logic b_en(int n);
        return (n < 7) ? en_base[n] : en_x[n-7];
    endfunction

    function automatic logic b_hi(int n);
        return (n < 7) ? pri_base[n] : pri_x[n-7];
    endfunction

    task automatic model_update();
        logic [14:0] p;
        int w;
        logic wl, nlo, nhi;
        logic [3:0] na;
        if (rst) begin
            m_req = 0; m_vec = 16'h0000; m_idx = 0; m_lvl = 0; m_lo = 0; m_hi = 0; m_auto = 0;
        end else begin
            p = b_pend(); w = -1; wl = 0;
            nlo = m_lo; nhi = m_hi; na = m_auto;
            if (en_base[7] && !m_hi)
                for (int n = 0; n < 15; n++)
                    if (w < 0 && n != 13 && p[n] && b_en(n) && b_hi(n)) begin w = n; wl = 1; end
            if (en_base[7] && w < 0 && !m_hi && !m_lo)
                for (int n = 0; n < 15; n++)
                    if (w < 0 && n != 13 && p[n] && b_en(n) && !b_hi(n)) begin w = n; wl = 0; end
            if (irq_reti) begin
                if (m_hi) nhi = 0; else nlo = 0;
            end
            if (m_req && irq_ack) begin
                if (m_lvl) nhi = 1; else nlo = 1;
            end
            for (int i = 0; i < 4; i++) begin
                if (evt_set[i]) na[i] = 1;
                else if (m_req && irq_ack && m_idx == i) na[i] = 0;
            end
            if (m_req) begin
                if (irq_ack) m_req = 0;
            end else if (w >= 0) begin
                m_req = 1; m_idx = w; m_lvl = wl; m_vec = 16'h0003 + 16'(w * 8);
            end
            m_lo = nlo; m_hi = nhi; m_auto = na;
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic cmp(string tag);
        checks++;
        if (irq_req !== m_req || irq_vec !== m_vec) begin
            fails++;
            $display("FAIL %s: req=%0b vec=%h expected req=%0b vec=%h", tag, irq_req, irq_vec, m_req, m_vec);
        end
    endtask

    task automatic expect_out(string tag, logic r, logic [15:0] v);
        checks++;
        if (irq_req !== r || irq_vec !== v) begin
            fails++;
            $display("FAIL %s: req=%0b vec=%h expected req=%0b vec=%h", tag, irq_req, irq_vec, r, v);
        end
    endtask

    task automatic clear_inputs();
        en_base = 0; en_x = 0; pri_base = 0; pri_x = 0; evt_set = 0; spi_f = 0;
        ser_f = 0; t2_f = 0; cmp_f = 0; t3_f = 0; smb_f = 0; pm = 0; adcw_f = 0;
        adcd_f = 0; pca_f = 0; irq_ack = 0; irq_reti = 0;
    endtask

    task automatic do_reset();
        rst = 1; clear_inputs();
        step(); step();
        expect_out("R1 reset state", 1'b0, 16'h0000);
        rst = 0;
    endtask

    task automatic pulse_ack();
        irq_ack = 1; step(); irq_ack = 0;
    endtask

    task automatic pulse_reti();
        irq_reti = 1; step(); irq_reti = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        clear_inputs();
        do_reset();

        // R5: global enable off blocks a pending serial request
        en_base = 8'h7F; en_x = 8'hFF; ser_f = 2'b01;
        step(); step();
        expect_out("R5 global off", 1'b0, 16'h0000);
        en_base = 8'hFF; step();
        expect_out("R2 serial vector", 1'b1, 16'h0023);
        step(); step();
        expect_out("R10 held without ack", 1'b1, 16'h0023);
        pulse_ack();
        expect_out("R10 drop after ack", 1'b0, 16'h0023);
        step();
        expect_out("R11 low blocks low", 1'b0, 16'h0023);
        pulse_reti(); step();
        expect_out("R7 level flag not cleared", 1'b1, 16'h0023);
        pulse_ack(); ser_f = 0;

        // R4/R8/R11: high SPI request pre-empts the low handler
        pri_base = 8'h40; spi_f = 4'b0100; step();
        expect_out("R8 SPI group / R11 preempt", 1'b1, 16'h0033);
        pulse_ack();
        pri_base = 8'h41; evt_set = 4'b0001; step(); evt_set = 0; step(); step();
        expect_out("R11 high not preempted", 1'b0, 16'h0033);
        pulse_reti(); step();
        expect_out("R3 lowest slot among high", 1'b1, 16'h0003);
        pulse_ack(); step();
        cmp("R10 after ack");
        spi_f = 0; pulse_reti(); pulse_reti(); step();
        expect_out("R7 stored bit cleared by vectoring", 1'b0, 16'h0003);

        // R3/R8: same level, PCA compare flag vs ADC window
        do_reset();
        en_base = 8'hFF; en_x = 8'hFF; pca_f = 7'b0000010; adcw_f = 1; step();
        expect_out("R3 same level order", 1'b1, 16'h004B);
        pulse_ack(); adcw_f = 0; pulse_reti(); step();
        expect_out("R8 PCA group", 1'b1, 16'h005B);

        // R4: high timer 3 beats low timer 2
        do_reset();
        en_base = 8'hFF; en_x = 8'hFF; pri_x = 8'h80; t2_f = 2'b01; t3_f = 2'b10; step();
        expect_out("R4 high beats lower slot", 1'b1, 16'h0073);

        // R6/R9/R5: reserved bits, port match live, enable removal
        do_reset();
        en_base = 8'hFF; en_x = 8'hFF; pri_base = 8'hFF; pri_x = 8'hFF; step(); step();
        expect_out("R6 reserved never requested", 1'b0, 16'h0000);
        pm = 1; step();
        expect_out("R9 port match live", 1'b1, 16'h0043);
        pulse_ack(); pulse_reti(); en_x = 8'hFD; step(); step();
        expect_out("R5 slot enable off", 1'b0, 16'h0043);
        pm = 0;

        // R7: set pulse in the acknowledge cycle wins
        do_reset();
        en_base = 8'hFF; evt_set = 4'b0010; step(); evt_set = 0; step();
        expect_out("R7 timer0 vector", 1'b1, 16'h000B);
        irq_ack = 1; evt_set = 4'b0010; step(); irq_ack = 0; evt_set = 0;
        expect_out("R7 ack cycle", 1'b0, 16'h000B);
        pulse_reti(); step();
        expect_out("R7 set wins over clear", 1'b1, 16'h000B);

        // Random phase: R3 R4 R5 R7 R10 R11 against the bench model
        do_reset();
        en_base = 8'hFF; en_x = 8'hFF;
        for (int c = 0; c < 4000; c++) begin
            if ($urandom % 40 == 0) begin
                en_base = 8'($urandom) | (($urandom % 6 == 0) ? 8'h00 : 8'h80);
                en_x = 8'($urandom); pri_base = 8'($urandom); pri_x = 8'($urandom);
            end
            evt_set = 0;
            for (int b = 0; b < 4; b++) if ($urandom % 12 == 0) evt_set[b] = 1;
            if ($urandom % 16 == 0) ser_f  = ser_f  ^ 2'(1 << ($urandom % 2));
            if ($urandom % 16 == 0) t2_f   = t2_f   ^ 2'(1 << ($urandom % 2));
            if ($urandom % 16 == 0) spi_f  = spi_f  ^ 4'(1 << ($urandom % 4));
            if ($urandom % 16 == 0) smb_f  = ~smb_f;
            if ($urandom % 16 == 0) pm     = ~pm;
            if ($urandom % 16 == 0) adcw_f = ~adcw_f;
            if ($urandom % 16 == 0) adcd_f = ~adcd_f;
            if ($urandom % 16 == 0) pca_f  = pca_f  ^ 7'(1 << ($urandom % 7));
            if ($urandom % 16 == 0) cmp_f  = cmp_f  ^ 2'(1 << ($urandom % 2));
            if ($urandom % 16 == 0) t3_f   = t3_f   ^ 2'(1 << ($urandom % 2));
            irq_ack  = m_req && ($urandom % 3 == 0);
            irq_reti = !irq_ack && (m_lo || m_hi) && ($urandom % 5 == 0);
            step();
            cmp("R3/R4/R5/R7/R10/R11 random");
        end
        clear_inputs();
        step();

        summary();
        $finish;
    end
endmodule